// File: doc/BRIEF.md
# Per-Flow Split Counter with Overflow Flushing

This block counts events for a set of flows at one update per clock cycle. Each flow owns a small on-chip counter held in registers. The full-width total for each flow lives in an external backing store. The backing store is slow and is not touched on the update path. Instead, a flow's small counter is emptied into the backing store just before it would run out of range. The block hands the accumulated amount out as a flush request, and the memory side adds it to the wide total. The small counter restarts from zero in the same cycle.

Flush requests wait in a short queue until the memory side takes them through a valid/ready handshake. If the queue has no room at the moment a flush is needed, the block raises an error pulse. It still keeps the increment wherever the small counter has space for it. A read port takes a flow index and the wide value that the memory side holds for that flow. It returns their sum with the flow's current small-counter value one cycle later. Counts only ever go up.

Top module: `flow_tally_engine`

## Requirements
- R1: After synchronous reset, every small counter is zero, the flush queue is empty, and `flush_valid`, `overflow_err` and `rd_ack` are low.
- R2: Each cycle with `upd_valid` high adds one to the small counter of `upd_flow`. Updates may come every cycle and to any flow.
- R3: When an update finds the counter at all-ones minus one (30 for a 5-bit counter), a flush entry is queued carrying the flow index and the amount 2^FAST_W-1 (31), and that counter becomes zero in the same cycle. `flush_valid` is high in the following cycle.
- R4: After a flush, the same flow produces no new flush until it has received another 2^FAST_W-1 updates.
- R5: Queued flushes leave in the order they were made. While `flush_valid` is high and `flush_ready` is low, `flush_flow` and `flush_amount` hold steady. An entry leaves on a clock edge where both are high.
- R6: The queue counts as full when it holds FIFO_DEPTH entries, whether or not an entry leaves in that same cycle. A flush needed while the queue is full pulses `overflow_err` high for one cycle, one cycle after the update. A counter at 30 still takes the increment and holds 31. A further update to a counter at 31 while the queue is still full is lost. A later update to a counter at 31 while there is room flushes the amount 2^FAST_W (32) and clears the counter.
- R7: A cycle with `rd_req` high gives `rd_ack` high in the next cycle, with `rd_total` = `rd_base` + the small counter of `rd_flow` as it stood before any update in the request cycle. `rd_ack` is low after a cycle without a request.
- R8: The queue holds up to FIFO_DEPTH entries (4 by default) while `flush_ready` stays low, and none of them is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | An increment is requested this cycle |
| upd_flow | input | IDX_W | Flow index of the increment |
| flush_valid | output | 1 | A flush entry is offered |
| flush_ready | input | 1 | The memory side accepts the offered entry |
| flush_flow | output | IDX_W | Flow index of the offered entry |
| flush_amount | output | FAST_W+1 | Amount to add to the wide total |
| overflow_err | output | 1 | A flush was needed but the queue was full |
| rd_req | input | 1 | Read request |
| rd_flow | input | IDX_W | Flow index to read |
| rd_base | input | WIDE_W | Wide total held by the memory side for `rd_flow` |
| rd_ack | output | 1 | Read result is valid |
| rd_total | output | WIDE_W | Wide total plus the current small count |

## Verification
The bench drives counters exactly onto the 30-to-31 boundary. A design with an off-by-one threshold would either wrap the counter to zero without flushing, or flush the wrong amount. With the memory side stalled, it fills the queue to its depth and then forces one more flush. A design that overwrote a queued entry, lost the saturated increment, or failed to raise the error would show up in the later read totals or in the drained order. It also checks the 32-count flush that follows a saturated counter. Long random runs with a throttled `flush_ready` and reads interleaved with same-cycle updates catch reads that return the post-update value and handshakes that drop or repeat an entry.

// File: rtl/flow_tally_pkg.sv
package flow_tally_pkg;

    localparam int DEF_FLOWS      = 16;
    localparam int DEF_FAST_W     = 5;
    localparam int DEF_WIDE_W     = 64;
    localparam int DEF_FIFO_DEPTH = 4;

    typedef enum logic [2:0] {
        UPD_IDLE,
        UPD_COUNT,
        UPD_FLUSH,
        UPD_SATURATE,
        UPD_LOST
    } upd_kind_e;

    // Decide what an update does to one small counter.
    function automatic upd_kind_e classify_update(
        input logic valid,
        input logic at_edge,
        input logic at_top,
        input logic room
    );
        upd_kind_e k;
        if (!valid)
            k = UPD_IDLE;
        else if (at_edge || at_top)
            k = room ? UPD_FLUSH : (at_top ? UPD_LOST : UPD_SATURATE);
        else
            k = UPD_COUNT;
        return k;
    endfunction

    function automatic logic is_drop(input upd_kind_e k);
        return (k == UPD_SATURATE) || (k == UPD_LOST);
    endfunction

endpackage

// File: rtl/tally_bank.sv
module tally_bank
    import flow_tally_pkg::*;
#(
    parameter int NUM_FLOWS = DEF_FLOWS,
    parameter int FAST_W    = DEF_FAST_W,
    localparam int IDX_W    = $clog2(NUM_FLOWS),
    localparam int AMT_W    = FAST_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_flow,
    input  logic             room,
    input  logic [IDX_W-1:0] rd_flow,
    output logic [FAST_W-1:0] rd_fast,
    output logic             push,
    output logic [IDX_W-1:0] push_flow,
    output logic [AMT_W-1:0] push_amt,
    output logic             drop_flag
);
    localparam logic [FAST_W-1:0] TOP  = '1;
    localparam logic [FAST_W-1:0] EDGE = TOP - FAST_W'(1);

    logic [FAST_W-1:0] cnt [NUM_FLOWS];
    logic [FAST_W-1:0] cur;
    logic [FAST_W-1:0] nxt;
    upd_kind_e         kind;

    assign cur  = cnt[upd_flow];
    assign kind = classify_update(upd_valid, cur == EDGE, cur == TOP, room);

    always_comb begin
        unique case (kind)
            UPD_COUNT, UPD_SATURATE: nxt = cur + FAST_W'(1);
            UPD_FLUSH:               nxt = '0;
            default:                 nxt = cur;
        endcase
    end

    assign push      = (kind == UPD_FLUSH);
    assign push_flow = upd_flow;
    assign push_amt  = {1'b0, cur} + AMT_W'(1);
    assign drop_flag = is_drop(kind);

    for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (kind != UPD_IDLE && upd_flow == IDX_W'(g))
                cnt[g] <= nxt;
        end
    end

    assign rd_fast = cnt[rd_flow];

endmodule

// File: rtl/tally_fifo.sv
module tally_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  fill;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (fill == '0);
    assign full    = (fill == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/tally_read.sv
module tally_read #(
    parameter int FAST_W = 5,
    parameter int WIDE_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [WIDE_W-1:0] rd_base,
    input  logic [FAST_W-1:0] rd_fast,
    output logic              rd_ack,
    output logic [WIDE_W-1:0] rd_total
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack   <= 1'b0;
            rd_total <= '0;
        end else begin
            rd_ack <= rd_req;
            if (rd_req)
                rd_total <= rd_base + WIDE_W'(rd_fast);
        end
    end

endmodule

// File: rtl/flow_tally_engine.sv
module flow_tally_engine
    import flow_tally_pkg::*;
#(
    parameter int NUM_FLOWS  = DEF_FLOWS,
    parameter int FAST_W     = DEF_FAST_W,
    parameter int WIDE_W     = DEF_WIDE_W,
    parameter int FIFO_DEPTH = DEF_FIFO_DEPTH,
    localparam int IDX_W     = $clog2(NUM_FLOWS),
    localparam int AMT_W     = FAST_W + 1,
    localparam int ENT_W     = IDX_W + AMT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_flow,
    output logic              flush_valid,
    input  logic              flush_ready,
    output logic [IDX_W-1:0]  flush_flow,
    output logic [AMT_W-1:0]  flush_amount,
    output logic              overflow_err,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_flow,
    input  logic [WIDE_W-1:0] rd_base,
    output logic              rd_ack,
    output logic [WIDE_W-1:0] rd_total
);
    logic              q_full, q_empty;
    logic              push, drop_flag;
    logic [IDX_W-1:0]  push_flow;
    logic [AMT_W-1:0]  push_amt;
    logic [FAST_W-1:0] rd_fast;
    logic [ENT_W-1:0]  q_out;

    tally_bank #(.NUM_FLOWS(NUM_FLOWS), .FAST_W(FAST_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_flow  (upd_flow),
        .room      (!q_full),
        .rd_flow   (rd_flow),
        .rd_fast   (rd_fast),
        .push      (push),
        .push_flow (push_flow),
        .push_amt  (push_amt),
        .drop_flag (drop_flag)
    );

    tally_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(ENT_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   ({push_flow, push_amt}),
        .pop   (flush_ready),
        .dout  (q_out),
        .empty (q_empty),
        .full  (q_full)
    );

    tally_read #(.FAST_W(FAST_W), .WIDE_W(WIDE_W)) u_read (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .rd_base  (rd_base),
        .rd_fast  (rd_fast),
        .rd_ack   (rd_ack),
        .rd_total (rd_total)
    );

    assign flush_valid  = !q_empty;
    assign flush_flow   = q_out[ENT_W-1:AMT_W];
    assign flush_amount = q_out[AMT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) overflow_err <= 1'b0;
        else     overflow_err <= drop_flag;
    end

endmodule

// File: rtl/tally_checks.sv
module tally_checks #(
    parameter int IDX_W  = 4,
    parameter int FAST_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_valid,
    input logic             flush_valid,
    input logic             flush_ready,
    input logic [IDX_W-1:0] flush_flow,
    input logic [FAST_W:0]  flush_amount,
    input logic             overflow_err,
    input logic             rd_req,
    input logic             rd_ack
);
    localparam logic [FAST_W:0] MIN_AMT = (FAST_W+1)'((1 << FAST_W) - 1);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!flush_valid && !overflow_err && !rd_ack));

    a_r5_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !flush_ready) |=> flush_valid);

    a_r5_hold_entry: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !flush_ready) |=> ($stable(flush_flow) && $stable(flush_amount)));

    a_r3_amount_floor: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> (flush_amount >= MIN_AMT));

    a_r3_flush_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_valid) |-> $past(upd_valid));

    a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
        overflow_err |-> $past(upd_valid));

    a_r7_ack_follows: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_ack);

    a_r7_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_ack);

endmodule

bind flow_tally_engine tally_checks #(.IDX_W(IDX_W), .FAST_W(FAST_W)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .upd_valid    (upd_valid),
    .flush_valid  (flush_valid),
    .flush_ready  (flush_ready),
    .flush_flow   (flush_flow),
    .flush_amount (flush_amount),
    .overflow_err (overflow_err),
    .rd_req       (rd_req),
    .rd_ack       (rd_ack)
);

// File: tb/test_flow_tally_engine.sv
module test_flow_tally_engine;
    localparam int FLOWS = 16;
    localparam int FW    = 5;
    localparam int WW    = 64;
    localparam int DEPTH = 4;
    localparam int IW    = $clog2(FLOWS);
    localparam int AW    = FW + 1;
    localparam int ALL   = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_flow = '0;
    logic          flush_valid;
    logic          flush_ready = 1'b0;
    logic [IW-1:0] flush_flow;
    logic [AW-1:0] flush_amount;
    logic          overflow_err;
    logic          rd_req = 1'b0;
    logic [IW-1:0] rd_flow = '0;
    logic [WW-1:0] rd_base = '0;
    logic          rd_ack;
    logic [WW-1:0] rd_total;

    always #5 clk = ~clk;

    flow_tally_engine #(.NUM_FLOWS(FLOWS), .FAST_W(FW), .WIDE_W(WW), .FIFO_DEPTH(DEPTH)) i_flow_tally_engine (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_flow(upd_flow),
        .flush_valid(flush_valid), .flush_ready(flush_ready), .flush_flow(flush_flow),
        .flush_amount(flush_amount), .overflow_err(overflow_err), .rd_req(rd_req),
        .rd_flow(rd_flow), .rd_base(rd_base), .rd_ack(rd_ack), .rd_total(rd_total)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int          mfast [FLOWS];
    logic [WW-1:0] store [FLOWS];
    int          q_flow [DEPTH+1];
    int          q_amt  [DEPTH+1];
    int          mcnt = 0;
    bit          exp_err = 0;
    bit          exp_ack = 0;
    logic [WW-1:0] exp_total = '0;
    string       tag = "R1";

    task automatic check(input string req, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int f, input bit rdy, input bit rq, input int rf);
        bit room;
        @(negedge clk);
        check(tag, "flush_valid", WW'(flush_valid), WW'(mcnt > 0));
        if (mcnt > 0) begin
            check(tag, "flush_flow", WW'(flush_flow), WW'(q_flow[0]));
            check(tag, "flush_amount", WW'(flush_amount), WW'(q_amt[0]));
        end
        check(tag, "overflow_err", WW'(overflow_err), WW'(exp_err));
        check(tag, "rd_ack", WW'(rd_ack), WW'(exp_ack));
        if (exp_ack) check(tag, "rd_total", rd_total, exp_total);
        upd_valid   = v;
        upd_flow    = IW'(f);
        flush_ready = rdy;
        rd_req      = rq;
        rd_flow     = IW'(rf);
        rd_base     = store[rf];
        exp_ack     = rq;
        exp_total   = store[rf] + WW'(mfast[rf]);
        room        = (mcnt < DEPTH);
        exp_err     = 0;
        if (rdy && mcnt > 0) begin
            store[q_flow[0]] += WW'(q_amt[0]);
            for (int i = 0; i < DEPTH; i++) begin
                q_flow[i] = q_flow[i+1];
                q_amt[i]  = q_amt[i+1];
            end
            mcnt--;
        end
        if (v) begin
            if (mfast[f] >= ALL - 1) begin
                if (room) begin
                    q_flow[mcnt] = f;
                    q_amt[mcnt]  = mfast[f] + 1;
                    mcnt++;
                    mfast[f] = 0;
                end else begin
                    exp_err = 1;
                    if (mfast[f] == ALL - 1) mfast[f] = ALL;
                end
            end else begin
                mfast[f]++;
            end
        end
        @(posedge clk);
    endtask

    task automatic drain();
        while (mcnt > 0) cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < FLOWS; i++) begin mfast[i] = 0; store[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: quiet outputs after reset and zero totals
        check("R1", "flush_valid", WW'(flush_valid), '0);
        check("R1", "overflow_err", WW'(overflow_err), '0);
        check("R1", "rd_ack", WW'(rd_ack), '0);
        @(posedge clk);
        tag = "R1";
        for (int f = 0; f < FLOWS; f++) cyc(0, 0, 1, 1, f);

        // R2: back-to-back updates across flows, read back with same-cycle updates (R7)
        tag = "R2";
        for (int n = 0; n < 3 * FLOWS; n++) cyc(1, n % FLOWS, 1, 1, (n * 7) % FLOWS);
        tag = "R7";
        for (int f = 0; f < FLOWS; f++) cyc(1, f, 1, 1, f);

        // R3: drive flow 3 to the boundary and across it
        tag = "R3";
        while (mfast[3] < ALL - 1) cyc(1, 3, 1, 0, 0);
        cyc(1, 3, 1, 1, 3);
        cyc(0, 0, 0, 1, 3);
        // R4: quiet window of 2^b-1 updates before the next flush
        tag = "R4";
        drain();
        for (int n = 0; n < ALL - 1; n++) cyc(1, 3, 1, 0, 0);
        cyc(1, 3, 1, 0, 0);
        drain();

        // R8: fill the queue with the memory side stalled
        tag = "R8";
        for (int f = 0; f < 5; f++) while (mfast[f] < ALL - 1) cyc(1, f, 0, 0, 0);
        for (int f = 0; f < DEPTH; f++) cyc(1, f, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        // R6: flush needed with a full queue, then a lost update
        tag = "R6";
        cyc(1, 4, 0, 0, 0);
        cyc(1, 4, 0, 1, 4);
        cyc(0, 0, 0, 1, 4);
        // R5: drain in order with bubbles on ready
        tag = "R5";
        for (int n = 0; n < 12; n++) cyc(0, 0, n % 3 != 0, 0, 0);
        tag = "R6";
        cyc(1, 4, 1, 0, 0);
        cyc(0, 0, 1, 1, 4);
        drain();

        // R2: random sweep with throttled ready and interleaved reads
        tag = "R2";
        for (int n = 0; n < 6000; n++)
            cyc(($urandom % 10) != 0, $urandom % FLOWS, ($urandom % 4) != 0,
                ($urandom % 5) == 0, $urandom % FLOWS);
        tag = "R7";
        drain();
        for (int f = 0; f < FLOWS; f++) cyc(0, 0, 1, 1, f);
        cyc(0, 0, 1, 0, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule